// File: doc/BRIEF.md
# Edge-Triggered External Interrupt Controller

This block turns level changes on general-purpose input pins into latched interrupt requests. It serves sixteen interrupt lines. Line n can watch pin n of any one of the implemented input ports, and a small source-select field picks which port that is. Each selected pin passes through a two-flop synchroniser. The synchronised value is then compared with its value one cycle earlier to find rising and falling transitions.

Each line has three control bits: a rising-edge enable, a falling-edge enable and an unmask bit. When an enabled transition is seen, the line's pending flag is set. The flag stays set until software writes a one to it. Writing a zero to a flag has no effect. One interrupt request output per line is high while the line's flag is set and the line is unmasked.

Software reaches all state through a word-addressed register port. Writes take effect on the clock edge. Reads are combinational.

Top module: `xirq_ctrl`

## Requirements
- R1: After reset, every register reads zero and `irq_out` is zero. This means every line is masked, no edge is enabled and every line selects port 0.
- R2: The source field for line n lies at register address n/4, bits [4*(n%4)+3 : 4*(n%4)]. The field reads back as written, and bits 31:16 of these registers read zero. Code k selects pin `port_pins[k*16+n]`.
- R3: A source code of 4 or more (at or above the number of implemented ports) acts as a constant-zero input, so toggling any pin sets no pending flag.
- R4: When the rising enable (address 5, bit n) is set, a 0-to-1 change on the selected pin sets pending bit n. A pin that changes just before clock edge k shows up in the pending register after edge k+2, and not after edge k+1.
- R5: When the falling enable (address 6, bit n) is set, a 1-to-0 change on the selected pin sets pending bit n. A 0-to-1 change does not set it unless the rising enable is also set.
- R6: With both enables set, either transition sets the flag. With neither set, no transition does.
- R7: `irq_out[n]` equals pending bit n ANDed with unmask bit n (address 4). A masked line still records its pending flag.
- R8: A write to the pending register (address 7) clears each bit written as one and leaves each bit written as zero. Writing back a value just read therefore clears every flag that was set.
- R9: If an enabled transition and a clear write hit the same bit in the same cycle, the bit ends up set.
- R10: The unmask and enable registers read back their low 16 bits as written, with bits 31:16 reading zero. The pending register reads the current flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Word address: 0-3 source select, 4 unmask, 5 rising enable, 6 falling enable, 7 pending |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| port_pins | input | NPORTS*NLINES | Raw pins; bit p*NLINES+n is pin n of port p |
| irq_out | output | NLINES | Per-line interrupt request |

## Verification
Randomised pin patterns are applied under every rotation of per-line source codes. A design that packed the select fields in the wrong place, or indexed the wrong port, would then flag lines whose selected pin never moved. A dedicated sequence places a clear write in exactly the cycle a new edge lands, so a design where the clear wins the race loses that interrupt. The sequence also moves the clear one cycle later and checks that the flag is then cleared.

A read-then-write-back of the pending register must empty it entirely; a design that only cleared the low bit would fail this. Out-of-range source codes are swept with both edge enables on, so a mux that wrapped or aliased the code onto a real port would raise spurious flags.

// File: rtl/xirq_pkg.sv
package xirq_pkg;

    localparam int ADDR_W         = 3;
    localparam int DATA_W         = 32;
    localparam int SEL_W          = 4;
    localparam int FIELDS_PER_REG = 4;

    // Source-select registers sit at addresses 0..3 (line n at n/4).
    localparam logic [ADDR_W-1:0] A_UNMASK = 3'd4;
    localparam logic [ADDR_W-1:0] A_RISE   = 3'd5;
    localparam logic [ADDR_W-1:0] A_FALL   = 3'd6;
    localparam logic [ADDR_W-1:0] A_PEND   = 3'd7;

    // Per-line synchroniser and history state
    typedef struct packed {
        logic meta;
        logic sync;
        logic prev;
    } sync_st_t;

endpackage

// File: rtl/xirq_cfg_regs.sv
module xirq_cfg_regs
    import xirq_pkg::*;
#(
    parameter int NLINES = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    we_i,
    input  logic [ADDR_W-1:0]       addr_i,
    input  logic [DATA_W-1:0]       wdata_i,
    input  logic [NLINES-1:0]       pend_i,
    output logic [NLINES*SEL_W-1:0] src_o,
    output logic [NLINES-1:0]       unmask_o,
    output logic [NLINES-1:0]       rise_o,
    output logic [NLINES-1:0]       fall_o,
    output logic [DATA_W-1:0]       rdata_o
);

    localparam int FIELD_BITS = FIELDS_PER_REG * SEL_W;

    typedef struct packed {
        logic [NLINES*SEL_W-1:0] src;
        logic [NLINES-1:0]       unmask;
        logic [NLINES-1:0]       rise;
        logic [NLINES-1:0]       fall;
    } cfg_t;

    cfg_t cfg_d, cfg_q;
    logic unused_wdata_hi;

    assign unused_wdata_hi = ^wdata_i[DATA_W-1:FIELD_BITS];

    always_comb begin
        cfg_d   = cfg_q;
        rdata_o = '0;
        if (we_i) begin
            for (int n = 0; n < NLINES; n++) begin
                if (addr_i == ADDR_W'(n / FIELDS_PER_REG)) begin
                    cfg_d.src[n*SEL_W +: SEL_W] =
                        wdata_i[(n % FIELDS_PER_REG)*SEL_W +: SEL_W];
                end
            end
            case (addr_i)
                A_UNMASK: cfg_d.unmask = wdata_i[NLINES-1:0];
                A_RISE:   cfg_d.rise   = wdata_i[NLINES-1:0];
                A_FALL:   cfg_d.fall   = wdata_i[NLINES-1:0];
                default:  ;
            endcase
        end
        for (int n = 0; n < NLINES; n++) begin
            if (addr_i == ADDR_W'(n / FIELDS_PER_REG)) begin
                rdata_o[(n % FIELDS_PER_REG)*SEL_W +: SEL_W] =
                    cfg_q.src[n*SEL_W +: SEL_W];
            end
        end
        case (addr_i)
            A_UNMASK: rdata_o[NLINES-1:0] = cfg_q.unmask;
            A_RISE:   rdata_o[NLINES-1:0] = cfg_q.rise;
            A_FALL:   rdata_o[NLINES-1:0] = cfg_q.fall;
            A_PEND:   rdata_o[NLINES-1:0] = pend_i;
            default:  ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign src_o    = cfg_q.src;
    assign unmask_o = cfg_q.unmask;
    assign rise_o   = cfg_q.rise;
    assign fall_o   = cfg_q.fall;

endmodule

// File: rtl/xirq_line.sv
module xirq_line
    import xirq_pkg::*;
#(
    parameter int NPORTS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NPORTS-1:0] pins_i,
    input  logic [SEL_W-1:0]  sel_i,
    input  logic              rise_en_i,
    input  logic              fall_en_i,
    output logic              edge_o
);

    sync_st_t st_d, st_q;
    logic     raw;

    always_comb begin
        // Codes at or above NPORTS match nothing and give a constant zero
        raw = 1'b0;
        for (int p = 0; p < NPORTS; p++) begin
            if (sel_i == SEL_W'(p)) raw = pins_i[p];
        end
        st_d.meta = raw;
        st_d.sync = st_q.meta;
        st_d.prev = st_q.sync;
        edge_o    = (rise_en_i &  st_q.sync & ~st_q.prev)
                  | (fall_en_i & ~st_q.sync &  st_q.prev);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/xirq_pend.sv
module xirq_pend #(
    parameter int NLINES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NLINES-1:0] set_i,
    input  logic              clr_we_i,
    input  logic [NLINES-1:0] clr_bits_i,
    output logic [NLINES-1:0] pend_o
);

    logic [NLINES-1:0] pend_d, pend_q;

    always_comb begin
        pend_d = pend_q;
        if (clr_we_i) pend_d = pend_d & ~clr_bits_i;
        // A fresh edge overrides a clear in the same cycle
        pend_d = pend_d | set_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= pend_d;
    end

    assign pend_o = pend_q;

endmodule

// File: rtl/xirq_ctrl.sv
module xirq_ctrl
    import xirq_pkg::*;
#(
    parameter int NLINES = 16,
    parameter int NPORTS = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     reg_we,
    input  logic [ADDR_W-1:0]        reg_addr,
    input  logic [DATA_W-1:0]        reg_wdata,
    output logic [DATA_W-1:0]        reg_rdata,
    input  logic [NPORTS*NLINES-1:0] port_pins,
    output logic [NLINES-1:0]        irq_out
);

    logic [NLINES*SEL_W-1:0] src_sel;
    logic [NLINES-1:0]       unmask_q;
    logic [NLINES-1:0]       rise_q;
    logic [NLINES-1:0]       fall_q;
    logic [NLINES-1:0]       edge_hit;
    logic [NLINES-1:0]       pend_q;
    logic                    clr_we;

    assign clr_we = reg_we && (reg_addr == A_PEND);

    xirq_cfg_regs #(.NLINES(NLINES)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .we_i     (reg_we),
        .addr_i   (reg_addr),
        .wdata_i  (reg_wdata),
        .pend_i   (pend_q),
        .src_o    (src_sel),
        .unmask_o (unmask_q),
        .rise_o   (rise_q),
        .fall_o   (fall_q),
        .rdata_o  (reg_rdata)
    );

    for (genvar n = 0; n < NLINES; n++) begin : g_line
        logic [NPORTS-1:0] line_pins;
        for (genvar p = 0; p < NPORTS; p++) begin : g_tap
            assign line_pins[p] = port_pins[p*NLINES + n];
        end
        xirq_line #(.NPORTS(NPORTS)) u_line (
            .clk       (clk),
            .rst_n     (rst_n),
            .pins_i    (line_pins),
            .sel_i     (src_sel[n*SEL_W +: SEL_W]),
            .rise_en_i (rise_q[n]),
            .fall_en_i (fall_q[n]),
            .edge_o    (edge_hit[n])
        );
    end

    xirq_pend #(.NLINES(NLINES)) u_pend (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_i      (edge_hit),
        .clr_we_i   (clr_we),
        .clr_bits_i (reg_wdata[NLINES-1:0]),
        .pend_o     (pend_q)
    );

    assign irq_out = pend_q & unmask_q;

endmodule

// File: rtl/xirq_ctrl_chk.sv
module xirq_ctrl_chk
    import xirq_pkg::*;
#(
    parameter int NLINES = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_we,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [NLINES-1:0] wdata_lo,
    input logic [NLINES-1:0] irq_out,
    input logic [NLINES-1:0] unmask_q,
    input logic [NLINES-1:0] rise_q,
    input logic [NLINES-1:0] fall_q,
    input logic [NLINES-1:0] edge_hit,
    input logic [NLINES-1:0] pend_q
);

    p_irq_masked_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_out & ~unmask_q) == '0);

    p_edge_needs_enable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_hit & ~(rise_q | fall_q)) == '0);

    p_set_only_on_edge_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q & ~$past(pend_q) & ~$past(edge_hit)) == '0);

    p_edge_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q & $past(edge_hit)) == $past(edge_hit));

    p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == A_PEND && (edge_hit & wdata_lo) == '0)
        |=> ((pend_q & $past(wdata_lo)) == '0));

endmodule

bind xirq_ctrl xirq_ctrl_chk #(.NLINES(NLINES)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_we   (reg_we),
    .reg_addr (reg_addr),
    .wdata_lo (reg_wdata[NLINES-1:0]),
    .irq_out  (irq_out),
    .unmask_q (unmask_q),
    .rise_q   (rise_q),
    .fall_q   (fall_q),
    .edge_hit (edge_hit),
    .pend_q   (pend_q)
);

// File: tb/xirq_ctrl_tb.sv
`timescale 1ns/1ps
module xirq_ctrl_tb;

    localparam int NL = 16;
    localparam int NP = 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            reg_we = 1'b0;
    logic [2:0]      reg_addr = '0;
    logic [31:0]     reg_wdata = '0;
    logic [31:0]     reg_rdata;
    logic [NP*NL-1:0] pins = '0;
    logic [NL-1:0]   irq;

    int          vectors = 0;
    int          miscompares = 0;
    logic [63:0] lfsr = 64'h9E37_79B9_7F4A_7C15;
    logic [31:0] rv;

    always #2 clk = ~clk;

    xirq_ctrl #(.NLINES(NL), .NPORTS(NP)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .port_pins (pins),
        .irq_out   (irq)
    );

    task automatic step_rand();
        for (int i = 0; i < 7; i++)
            lfsr = {lfsr[62:0], lfsr[63] ^ lfsr[62] ^ lfsr[60] ^ lfsr[59]};
    endtask

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic idle(input int k);
        repeat (k) @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic chk_pend(input string tag, input logic [NL-1:0] exp);
        logic [31:0] v;
        rd(3'd7, v);
        check(tag, {32'd0, v}, {48'd0, exp});
    endtask

    task automatic set_all_src(input logic [3:0] code);
        for (int r = 0; r < 4; r++) wr(3'(r), {16'd0, {4{code}}});
    endtask

    task automatic flush_clear();
        idle(4);
        wr(3'd7, 32'h0000_FFFF);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);

        // R1: reset state
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), rv);
            check("R1 reset read", {32'd0, rv}, 64'd0);
        end
        check("R1 reset irq", {48'd0, irq}, 64'd0);

        // R10 / R2: readback and unused upper bits
        wr(3'd4, 32'hFFFF_FFFF); rd(3'd4, rv); check("R10 unmask rb", {32'd0, rv}, 64'h0000_FFFF);
        wr(3'd5, 32'h1234_5678); rd(3'd5, rv); check("R10 rise rb", {32'd0, rv}, 64'h0000_5678);
        wr(3'd6, 32'h9ABC_DEF0); rd(3'd6, rv); check("R10 fall rb", {32'd0, rv}, 64'h0000_DEF0);
        wr(3'd2, 32'hFFFF_FFFF); rd(3'd2, rv); check("R2 src rb", {32'd0, rv}, 64'h0000_FFFF);
        wr(3'd4, 0); wr(3'd5, 0); wr(3'd6, 0); set_all_src(4'd0);

        // R4: latency of a single rising edge on line 5
        wr(3'd5, 32'h0000_FFFF);
        flush_clear();
        @(negedge clk); pins[5] = 1'b1;
        @(negedge clk); chk_pend("R4 latency edge+1", '0);
        @(negedge clk); chk_pend("R4 latency edge+2", '0);
        @(negedge clk); chk_pend("R4 latency edge+3", 16'h0020);
        pins = '0;

        // R2: rotated per-line source codes, random pin patterns
        wr(3'd4, 32'h0000_FFFF);
        for (int k = 0; k < 4; k++) begin
            for (int r = 0; r < 4; r++) begin
                logic [31:0] val;
                val = '0;
                for (int f = 0; f < 4; f++) val[f*4 +: 4] = 4'((r*4 + f + k) % 4);
                wr(3'(r), val);
                rd(3'(r), rv);
                check("R2 field rb", {32'd0, rv}, {32'd0, val});
            end
            for (int i = 0; i < 6; i++) begin
                logic [NL-1:0] e;
                pins = '0;
                flush_clear();
                step_rand();
                pins = lfsr;
                idle(4);
                for (int n = 0; n < NL; n++) e[n] = lfsr[((n + k) % 4)*NL + n];
                chk_pend("R2 port select pend", e);
                check("R2 port select irq", {48'd0, irq}, {48'd0, e});
            end
        end
        pins = '0;

        // R3: out-of-range source codes give no edges
        wr(3'd5, 32'h0000_FFFF); wr(3'd6, 32'h0000_FFFF);
        for (int c = 4; c < 16; c++) begin
            set_all_src(4'(c));
            flush_clear();
            pins = '1; idle(4);
            chk_pend("R3 invalid code rise", '0);
            pins = '0; idle(4);
            chk_pend("R3 invalid code fall", '0);
        end
        set_all_src(4'd0);

        // R5 / R6: per-line enable mixes, rising then falling
        for (int j = 0; j < 8; j++) begin
            logic [NL-1:0] re, fe, x;
            step_rand();
            re = lfsr[15:0]; fe = lfsr[31:16]; x = lfsr[47:32];
            if (j == 0) begin re = '1; fe = '0; end
            if (j == 1) begin re = '0; fe = '1; end
            if (j == 2) begin re = '1; fe = '1; end
            if (j == 3) begin re = '0; fe = '0; end
            wr(3'd5, {16'd0, re}); wr(3'd6, {16'd0, fe});
            pins = '0;
            flush_clear();
            pins[NL-1:0] = x; idle(4);
            chk_pend("R6 rise with mixed enables", x & re);
            wr(3'd7, 32'h0000_FFFF);
            pins = '0; idle(4);
            chk_pend("R5 fall with mixed enables", x & fe);
        end

        // R7: mask gates only the request
        wr(3'd5, 32'h0000_FFFF); wr(3'd6, 0);
        pins = '0; flush_clear();
        pins[NL-1:0] = 16'hA5C3; idle(4);
        for (int m = 0; m < 8; m++) begin
            logic [NL-1:0] mk;
            step_rand();
            mk = lfsr[15:0];
            if (m == 0) mk = '0;
            if (m == 1) mk = '1;
            wr(3'd4, {16'd0, mk});
            check("R7 irq gated", {48'd0, irq}, {48'd0, 16'hA5C3 & mk});
            chk_pend("R7 pending kept while masked", 16'hA5C3);
        end
        wr(3'd4, 32'h0000_FFFF);

        // R8: write-one-to-clear
        pins[NL-1:0] = 16'hFFFF; idle(4);
        chk_pend("R8 all set", 16'hFFFF);
        wr(3'd7, 32'h0000_0000); chk_pend("R8 zero write keeps", 16'hFFFF);
        wr(3'd7, 32'hFFFF_00F0); chk_pend("R8 partial clear", 16'hFF0F);
        rd(3'd7, rv);
        wr(3'd7, rv);
        chk_pend("R8 read-write-back clears all", '0);
        check("R8 irq after clear", {48'd0, irq}, 64'd0);

        // R9: edge and clear in the same cycle
        wr(3'd5, 32'h0000_FFFF); wr(3'd6, 32'h0000_FFFF);
        pins = '0; flush_clear();
        chk_pend("R9 start clear", '0);
        @(negedge clk); pins[0] = 1'b1;
        @(negedge clk);
        @(negedge clk); reg_addr = 3'd7; reg_wdata = 32'h1; reg_we = 1'b1;
        @(negedge clk); reg_we = 1'b0;
        chk_pend("R9 edge wins over clear", 16'h0001);
        // clear one cycle after the set: bit ends cleared
        @(negedge clk); pins[0] = 1'b0;
        @(negedge clk);
        @(negedge clk);
        @(negedge clk); chk_pend("R9 set before late clear", 16'h0001);
        reg_addr = 3'd7; reg_wdata = 32'h1; reg_we = 1'b1;
        @(negedge clk); reg_we = 1'b0;
        chk_pend("R9 late clear takes effect", '0);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule